// File: doc/BRIEF.md
# ATA Task-File Register and Command Unit

This block is the drive-side register file and command sequencer for a channel that carries one drive. A host reaches it through byte-wide register accesses at offsets 0 to 7. Offset 0 is a 16-bit read-only data port. The unit keeps the drive's status and error bytes and drives the interrupt request line. It runs three kinds of command. The identify command exposes a fixed 256-word image through programmed-I/O reads of the data port. The flush command keeps the drive busy for a parameterised number of cycles. Every other command code is rejected with an abort.

The block holds no media. The identify image is built from two text parameters, one for the serial number and one for the firmware revision, and a few fixed capability words. The status byte is sequenced by the command that is running. Reading the status register acknowledges the interrupt.

Register offsets:

| Offset | Read | Write |
|---|---|---|
| 0 | data port | ignored |
| 1 | error | ignored |
| 2 to 5 | stored byte | stored byte |
| 6 | device register | device register |
| 7 | status | command |

Top module: `ata_taskfile_unit`

## Requirements
- R1: A byte written to any of offsets 2, 3, 4, 5 or 6 reads back unchanged from the same offset, in the low byte of `rd_data`, with the high byte zero. The device register at offset 6 stores all eight bits. Bit 4 of that register selects device 1, and bit 6 selects LBA addressing.
- R2: After reset, the status byte reads 0x40, meaning only the ready bit is set. The error byte reads 0x00 and `intrq` is low.
- R3: The status bits are busy 0x80, ready 0x40, fault 0x20, data-request 0x08 and error 0x01. Writing 0xEC to offset 7 starts identify. From then on, status reads 0x48 for each of 256 data-word reads at offset 0. The cycle after the 256th read, status reads 0x40.
- R4: The identify words are as follows. Word 0 is 0x0040. Word 85 has bit 5 set (value 0x0020), meaning the write cache is on. Words 10 to 19 hold the 20-character serial text and words 23 to 26 hold the 8-character revision text, with the earlier character of each pair in bits 15:8. All other words are zero.
- R5: Writing 0xE7 to offset 7 starts a flush. Status reads 0xC0 for exactly FLUSH_CYCLES cycles after the write cycle, then 0x40.
- R6: Any other command code sets status to 0x41 and the error byte to 0x04 (abort). This includes 0xC8, 0xCA and 0x06.
- R7: A read at offset 7 lowers `intrq` at the following clock edge, unless a command completes at that same edge. Reads at other offsets leave `intrq` unchanged.
- R8: Three events count as command completion: identify data becoming ready, an abort, and the end of a flush. Completion raises `intrq` only when device register bit 4 is 0. When that bit is 1, `intrq` stays low.
- R9: A command write while busy is set has no effect on status, the error byte or the running flush.
- R10: An accepted identify or flush clears the error bit in status and clears the error byte to 0x00.
- R11: A data-port read while data-request is clear returns 0x0000 and changes neither status nor `intrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe; side effects take place at the clock edge |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset 0 to 7 |
| wr_byte | input | 8 | Write data |
| rd_data | output | 16 | Read data, valid combinationally while `rd_en` is high |
| intrq | output | 1 | Interrupt request line |

## Verification
Properties in the controller run on every cycle. They check that a status read drops the interrupt when no completion coincides with it. They check that the interrupt rises only with device 0 selected, that an error bit always comes with the abort code, and that a command written while busy leaves the error byte unchanged. They also check that data-request falls after the last identify word and that the end of a flush raises the interrupt when device 0 is selected.

Only the bench scenarios can show the rest. These are the exact contents of the identify image and its byte order, the exact length of the busy window, register read-back, and that a command swallowed during a flush leaves no trace once the flush ends. A behavioural model of the status and interrupt is compared against the design on every clock.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_ERROR  = 3'd1;
  localparam logic [2:0] OFS_DEVICE = 3'd6;
  localparam logic [2:0] OFS_CMDSTS = 3'd7;

  localparam logic [7:0] CMD_IDENTIFY = 8'hEC;
  localparam logic [7:0] CMD_FLUSH    = 8'hE7;

  localparam logic [7:0] ERRB_ABORT = 8'h04;

  localparam int STB_BUSY  = 7;
  localparam int STB_READY = 6;
  localparam int STB_FAULT = 5;
  localparam int STB_DREQ  = 3;
  localparam int STB_ERR   = 0;

  localparam int DEVB_SEL1 = 4;

  typedef enum logic [1:0] {
    CTL_IDLE  = 2'd0,
    CTL_XFER  = 2'd1,
    CTL_FLUSH = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/ata_tf_shadow.sv
module ata_tf_shadow #(
  parameter int FIRST_OFS = 2,
  parameter int NUM_REGS  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              reg_addr,
  input  logic [7:0]              wr_byte,
  output logic [NUM_REGS*8-1:0]   regs_flat
);
  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic       hit;
      logic [7:0] val_q;
      logic [7:0] val_d;

      assign hit = wr_en && (reg_addr == 3'(FIRST_OFS + g));

      always_comb begin
        val_d = val_q;
        if (hit) val_d = wr_byte;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= 8'h00;
        else        val_q <= val_d;
      end

      assign regs_flat[g*8 +: 8] = val_q;
    end
  endgenerate
endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
  parameter int               PW          = 8,
  parameter logic [159:0]     SERIAL_TXT  = "UNIT-SERIAL-00000001",
  parameter logic [63:0]      VERSION_TXT = "REV 1.00"
) (
  input  logic [PW-1:0] idx,
  output logic [15:0]   word
);
  localparam int SER_FIRST = 10;
  localparam int SER_WORDS = 10;
  localparam int VER_FIRST = 23;
  localparam int VER_WORDS = 4;
  localparam int CAP_WORD  = 85;

  always_comb begin
    int i;
    i = int'(idx);
    word = 16'h0000;
    if (i == 0) begin
      word = 16'h0040;
    end else if (i >= SER_FIRST && i < SER_FIRST + SER_WORDS) begin
      word = SERIAL_TXT[159 - 16*(i - SER_FIRST) -: 16];
    end else if (i >= VER_FIRST && i < VER_FIRST + VER_WORDS) begin
      word = VERSION_TXT[63 - 16*(i - VER_FIRST) -: 16];
    end else if (i == CAP_WORD) begin
      word = 16'h0020;
    end
  end
endmodule

// File: rtl/ata_tf_cmdctl.sv
module ata_tf_cmdctl
  import ata_tf_pkg::*;
#(
  parameter int FLUSH_CYCLES = 40,
  parameter int IDENT_WORDS  = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_wr,
  input  logic [7:0]                     cmd_code,
  input  logic                           stat_rd,
  input  logic                           data_rd,
  input  logic                           dev1_sel,
  output logic [7:0]                     status,
  output logic [7:0]                     err_byte,
  output logic [$clog2(IDENT_WORDS)-1:0] word_idx,
  output logic                           intrq
);
  localparam int CW = $clog2(FLUSH_CYCLES + 1);
  localparam int PW = $clog2(IDENT_WORDS);
  localparam logic [CW-1:0] CNT_LOAD = CW'(FLUSH_CYCLES - 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(IDENT_WORDS - 1);

  ctl_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          errf_q, errf_d;
  logic [7:0]    errb_q, errb_d;
  logic          irq_q, irq_d;
  logic          done;
  logic          busy, dreq;

  assign busy = (st_q == CTL_FLUSH);
  assign dreq = (st_q == CTL_XFER);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    errf_d = errf_q;
    errb_d = errb_q;
    irq_d  = irq_q;
    done   = 1'b0;
    if (stat_rd) irq_d = 1'b0;
    if (busy) begin
      if (cnt_q == '0) begin
        st_d = CTL_IDLE;
        done = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (cmd_wr) begin
      case (cmd_code)
        CMD_IDENTIFY: begin
          st_d   = CTL_XFER;
          ptr_d  = '0;
          errf_d = 1'b0;
          errb_d = 8'h00;
          done   = 1'b1;
        end
        CMD_FLUSH: begin
          st_d   = CTL_FLUSH;
          cnt_d  = CNT_LOAD;
          errf_d = 1'b0;
          errb_d = 8'h00;
        end
        default: begin
          st_d   = CTL_IDLE;
          errf_d = 1'b1;
          errb_d = ERRB_ABORT;
          done   = 1'b1;
        end
      endcase
    end else if (dreq && data_rd) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == PTR_LAST) st_d = CTL_IDLE;
    end
    if (done && !dev1_sel) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CTL_IDLE;
      cnt_q  <= '0;
      ptr_q  <= '0;
      errf_q <= 1'b0;
      errb_q <= 8'h00;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      errf_q <= errf_d;
      errb_q <= errb_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    status            = 8'h00;
    status[STB_BUSY]  = busy;
    status[STB_READY] = 1'b1;
    status[STB_FAULT] = 1'b0;
    status[STB_DREQ]  = dreq;
    status[STB_ERR]   = errf_q;
  end

  assign err_byte = errb_q;
  assign word_idx = ptr_q;
  assign intrq    = irq_q;

  // R7: a status read with no completion possible drops the line
  assert_stat_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !busy && !cmd_wr) |=> !intrq);

  // R8: the line only rises after a cycle with device 0 selected
  assert_irq_dev0_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq) |-> $past(!dev1_sel));

  // R6: an error bit in status always comes with the abort code
  assert_err_has_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[STB_ERR] |-> err_byte[2]);

  // R9: a command written while busy leaves the error byte unchanged
  assert_busy_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(err_byte));

  // R3: data request falls after the last identify word
  assert_xfer_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && data_rd && !cmd_wr && word_idx == PTR_LAST) |=> !status[STB_DREQ]);

  // R5: end of flush raises the line when device 0 is selected
  assert_flush_end_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[STB_BUSY]) |-> (intrq || $past(dev1_sel)));
endmodule

// File: rtl/ata_taskfile_unit.sv
module ata_taskfile_unit
  import ata_tf_pkg::*;
#(
  parameter int           FLUSH_CYCLES = 40,
  parameter int           IDENT_WORDS  = 256,
  parameter logic [159:0] SERIAL_TXT   = "UNIT-SERIAL-00000001",
  parameter logic [63:0]  VERSION_TXT  = "REV 1.00"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  wr_byte,
  output logic [15:0] rd_data,
  output logic        intrq
);
  localparam int SH_FIRST = 2;
  localparam int SH_NUM   = 5;
  localparam int PW       = $clog2(IDENT_WORDS);

  logic [SH_NUM*8-1:0] sh_flat;
  logic [7:0]          status, err_byte, dev_reg;
  logic [PW-1:0]       word_idx;
  logic [15:0]         id_word;
  logic                cmd_wr, stat_rd, data_rd;

  assign cmd_wr  = wr_en && (reg_addr == OFS_CMDSTS);
  assign stat_rd = rd_en && (reg_addr == OFS_CMDSTS);
  assign data_rd = rd_en && (reg_addr == OFS_DATA);
  assign dev_reg = sh_flat[(int'(OFS_DEVICE) - SH_FIRST)*8 +: 8];

  ata_tf_shadow #(.FIRST_OFS(SH_FIRST), .NUM_REGS(SH_NUM)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_addr  (reg_addr),
    .wr_byte   (wr_byte),
    .regs_flat (sh_flat)
  );

  ata_tf_cmdctl #(.FLUSH_CYCLES(FLUSH_CYCLES), .IDENT_WORDS(IDENT_WORDS)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_code (wr_byte),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .dev1_sel (dev_reg[DEVB_SEL1]),
    .status   (status),
    .err_byte (err_byte),
    .word_idx (word_idx),
    .intrq    (intrq)
  );

  ata_tf_ident #(.PW(PW), .SERIAL_TXT(SERIAL_TXT), .VERSION_TXT(VERSION_TXT)) u_ident (
    .idx  (word_idx),
    .word (id_word)
  );

  always_comb begin
    rd_data = 16'h0000;
    case (reg_addr)
      OFS_DATA:   rd_data = status[STB_DREQ] ? id_word : 16'h0000;
      OFS_ERROR:  rd_data = {8'h00, err_byte};
      OFS_CMDSTS: rd_data = {8'h00, status};
      default:    rd_data = {8'h00, sh_flat[(int'(reg_addr) - SH_FIRST)*8 +: 8]};
    endcase
  end
endmodule

// File: tb/tb_ata_taskfile_unit.sv
module tb_ata_taskfile_unit;
  localparam int FLUSH = 40;
  localparam string SER = "UNIT-SERIAL-00000001";
  localparam string VER = "REV 1.00";

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] wr_byte = 0;
  logic [15:0] rd_data;
  logic intrq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  ata_taskfile_unit #(.FLUSH_CYCLES(FLUSH)) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .reg_addr(reg_addr), .wr_byte(wr_byte), .rd_data(rd_data), .intrq(intrq));

  // behavioural reference: 0 idle, 1 transfer, 2 flushing
  int m_st = 0, m_ptr = 0, m_rem = 0;
  bit m_err = 0, m_irq = 0;
  int m_errb = 0;
  int m_dev = 0;

  function automatic int m_status();
    return 'h40 | (m_st == 2 ? 'h80 : 0) | (m_st == 1 ? 'h08 : 0) | (m_err ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_rem = 0; m_err = 0; m_irq = 0; m_errb = 0; m_dev = 0;
    end else begin
      bit fin;
      fin = 0;
      if (m_st == 2) begin
        m_rem--;
        if (m_rem == 0) begin m_st = 0; fin = 1; end
      end else if (wr_en && reg_addr == 7) begin
        if (wr_byte == 8'hEC) begin
          m_st = 1; m_ptr = 0; m_err = 0; m_errb = 0; fin = 1;
        end else if (wr_byte == 8'hE7) begin
          m_st = 2; m_rem = FLUSH; m_err = 0; m_errb = 0;
        end else begin
          m_st = 0; m_err = 1; m_errb = 4; fin = 1;
        end
      end else if (m_st == 1 && rd_en && reg_addr == 0) begin
        m_ptr++;
        if (m_ptr == 256) m_st = 0;
      end
      if (rd_en && reg_addr == 7) m_irq = 0;
      if (fin && !m_dev[4]) m_irq = 1;
      if (wr_en && reg_addr == 6) m_dev = wr_byte;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // interrupt compared with the model on every clock (R7, R8)
  always @(negedge clk) if (rst_n) check(intrq == m_irq, "R7/R8 intrq", intrq, m_irq);

  function automatic int id_exp(input int i);
    if (i == 0) return 'h0040;
    if (i >= 10 && i <= 19) return {SER[2*(i-10)], SER[2*(i-10)+1]};
    if (i >= 23 && i <= 26) return {VER[2*(i-23)], VER[2*(i-23)+1]};
    if (i == 85) return 'h0020;
    return 0;
  endfunction

  task automatic idle();
    @(negedge clk); rd_en = 0; wr_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); rd_en = 0; wr_en = 1; reg_addr = a; wr_byte = d;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk); wr_en = 0; rd_en = 1; reg_addr = a;
    #1 check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic rd_stat(input string tag);
    @(negedge clk); wr_en = 0; rd_en = 1; reg_addr = 7;
    #1 check(rd_data == m_status(), tag, rd_data, m_status());
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int busy_n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    check(intrq == 0, "R2 intrq", intrq, 0);
    rd_chk(7, 'h40, "R2 status");
    rd_chk(1, 'h00, "R2 error");
    // R1 register read-back
    for (int a = 2; a <= 6; a++) wr(3'(a), 8'(8'h51 + a * 8'h13));
    for (int a = 2; a <= 6; a++) rd_chk(3'(a), 8'h51 + a * 8'h13, "R1 readback");
    wr(6, 8'h50);
    rd_chk(6, 'h50, "R1 device LBA+dev1");
    wr(6, 8'h40);
    rd_chk(6, 'h40, "R1 device LBA dev0");
    // R11 idle data read
    rd_chk(0, 0, "R11 idle data");
    rd_chk(7, 'h40, "R11 status unchanged");
    // R3/R4 identify
    wr(7, 8'hEC);
    rd_chk(1, 'h00, "R7 error read keeps irq");
    idle();
    check(intrq == 1, "R8 identify irq", intrq, 1);
    for (int i = 0; i < 256; i++) begin
      rd_stat("R3 status during identify");
      rd_chk(0, id_exp(i), "R4 identify word");
    end
    rd_stat("R3 status after identify");
    rd_chk(7, 'h40, "R3 final status");
    // R6 rejected codes
    wr(7, 8'hC8); rd_chk(7, 'h41, "R6 status C8"); rd_chk(1, 'h04, "R6 error C8");
    wr(7, 8'hCA); rd_chk(7, 'h41, "R6 status CA");
    wr(7, 8'h06); rd_chk(1, 'h04, "R6 error 06");
    // R5/R9/R10 flush with command written while busy
    wr(7, 8'hE7);
    rd_chk(1, 'h00, "R10 error cleared");
    wr(7, 8'h00);
    wr(7, 8'hEC);
    busy_n = 3;
    for (int k = 0; k < FLUSH + 5; k++) begin
      rd_stat("R5 flush status");
      if (rd_data[7]) busy_n++;
    end
    check(busy_n == FLUSH, "R5 busy length", busy_n, FLUSH);
    rd_chk(7, 'h40, "R9 no trace after flush");
    rd_chk(1, 'h00, "R9 error untouched");
    // R8 device 1 selected: no interrupt
    wr(6, 8'h10);
    wr(7, 8'h99);
    idle(); idle();
    check(intrq == 0, "R8 dev1 no irq", intrq, 0);
    rd_chk(7, 'h41, "R8 abort status dev1");
    wr(6, 8'h00);
    wr(7, 8'hE7);
    repeat (FLUSH + 2) idle();
    check(intrq == 1, "R5 flush end irq", intrq, 1);
    rd_stat("R10 flush clears err");
    idle(); idle();
    finish_run();
  end
endmodule